// File: doc/BRIEF.md
# Lockable system configuration register bank

This block is the configuration register bank of a small secure SoC. It sits on a simple CPU bus that carries chip select, write enable, an 8-bit word address and 32-bit data. It holds three identification words, an execution-mode flag, LED and GPIO control bits, the load address and size of the application, a pointer to a hash routine, and an eight-word (256-bit) device secret.

Boot firmware fills in the application fields, the hash pointer and the secret, and then sets the mode flag. From that point the device is in application mode and those privileged registers are frozen until the next reset. The LED and GPIO registers stay writable in both modes, and every register can still be read. Reads return data one cycle after the request.

Top module: `sys_cfg_regs`

## Requirements
- R1: Addresses 0x00 and 0x01 return the name words (default 32'h6366_6731 and 32'h7265_6773), and 0x02 returns the version word (default 32'h0000_0003). Writes to these addresses have no effect.
- R2: Address 0x08 holds the mode flag. It is 0 after reset, which is firmware mode. A write of any nonzero value sets it, a write of zero leaves it unchanged, and once set it stays at 1 until reset. It reads back as bit 0 and drives `app_mode_o`.
- R3: The LED register at 0x09 drives `led_o`, with bit 0 for blue, bit 1 for green and bit 2 for red. It is writable in both modes and reads back its value in bits 2:0.
- R4: A write to 0x0a stores bits 3:0, which drive `gpio_o`. This works in both modes. A read of 0x0a returns the levels on `gpio_i` in bits 3:0.
- R5: The app start (0x0c), app size (0x0d) and hash pointer (0x10) registers take writes in firmware mode. Writes to them are ignored in application mode, and they stay readable.
- R6: The secret words at 0x20 to 0x27 take writes in firmware mode. Writes to them are ignored in application mode, and they stay readable in both modes.
- R7: A read of any address not listed in R1 to R6 returns zero.
- R8: A read presents its data on `rdata_o` in the cycle after the request. In any cycle that follows a cycle with no read request, `rdata_o` is zero.
- R9: Reset clears every writable register (mode, LED, GPIO, app start, app size, hash pointer, secret) to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus chip select |
| we_i | input | 1 | Write enable; a read when low |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| led_o | output | 3 | LED drive {red, green, blue} |
| gpio_i | input | 4 | GPIO pin levels |
| gpio_o | output | 4 | GPIO output values |
| app_mode_o | output | 1 | High in application mode |

## Verification
The bench first fills every register with distinct values in firmware mode and reads each one back, so that a swapped address decode shows up as a wrong word. It then sets the mode flag and repeats the writes with new values. Privileged registers must return their old contents, while LED and GPIO must take the new ones; this separates correct locking from locking that covers too much or too little. Zero writes to the mode flag, reads of unmapped addresses and idle cycles show whether the flag is sticky and whether read data leaks outside read requests. A second reset shows that every field clears and firmware mode returns.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;
  localparam int ADDR_W = 8;
  localparam int LED_W  = 3;
  localparam int GPIO_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_NAME0    = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_NAME1    = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_VERSION  = 8'h02;
  localparam logic [ADDR_W-1:0] ADDR_MODE     = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_LED      = 8'h09;
  localparam logic [ADDR_W-1:0] ADDR_GPIO     = 8'h0a;
  localparam logic [ADDR_W-1:0] ADDR_APP_BASE = 8'h0c;
  localparam logic [ADDR_W-1:0] ADDR_APP_LEN  = 8'h0d;
  localparam logic [ADDR_W-1:0] ADDR_HASH_PTR = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_SECRET   = 8'h20;
endpackage

// File: rtl/cfg_mode_lock.sv
module cfg_mode_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic app_mode_o
);
  // sticky: only reset returns to firmware mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    app_mode_o <= 1'b0;
    else if (set_i) app_mode_o <= 1'b1;
  end
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file import sys_cfg_pkg::*; #(
  parameter int DATA_W       = 32,
  parameter int SECRET_WORDS = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   wr_i,
  input  logic [ADDR_W-1:0]                      addr_i,
  input  logic [DATA_W-1:0]                      wdata_i,
  input  logic                                   lock_i,
  output logic [LED_W-1:0]                       led_o,
  output logic [GPIO_W-1:0]                      gpio_o,
  output logic [DATA_W-1:0]                      app_start_o,
  output logic [DATA_W-1:0]                      app_size_o,
  output logic [DATA_W-1:0]                      hash_ptr_o,
  output logic [SECRET_WORDS-1:0][DATA_W-1:0]    secret_o
);
  logic wr_priv;
  assign wr_priv = wr_i & ~lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_o  <= '0;
      gpio_o <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_LED)  led_o  <= wdata_i[LED_W-1:0];
      if (addr_i == ADDR_GPIO) gpio_o <= wdata_i[GPIO_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_start_o <= '0;
      app_size_o  <= '0;
      hash_ptr_o  <= '0;
    end else if (wr_priv) begin
      if (addr_i == ADDR_APP_BASE) app_start_o <= wdata_i;
      if (addr_i == ADDR_APP_LEN)  app_size_o  <= wdata_i;
      if (addr_i == ADDR_HASH_PTR) hash_ptr_o  <= wdata_i;
    end
  end

  for (genvar g = 0; g < SECRET_WORDS; g++) begin : g_secret
    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_SECRET + ADDR_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             secret_o[g] <= '0;
      else if (wr_priv && addr_i == WORD_ADDR) secret_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux import sys_cfg_pkg::*; #(
  parameter int                DATA_W       = 32,
  parameter int                SECRET_WORDS = 8,
  parameter logic [DATA_W-1:0] NAME0_VAL    = '0,
  parameter logic [DATA_W-1:0] NAME1_VAL    = '0,
  parameter logic [DATA_W-1:0] VERSION_VAL  = '0
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                rd_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic                                app_mode_i,
  input  logic [LED_W-1:0]                    led_i,
  input  logic [GPIO_W-1:0]                   gpio_i,
  input  logic [DATA_W-1:0]                   app_start_i,
  input  logic [DATA_W-1:0]                   app_size_i,
  input  logic [DATA_W-1:0]                   hash_ptr_i,
  input  logic [SECRET_WORDS-1:0][DATA_W-1:0] secret_i,
  output logic [DATA_W-1:0]                   rdata_o
);
  localparam int IDX_W = (SECRET_WORDS > 1) ? $clog2(SECRET_WORDS) : 1;

  logic [ADDR_W-1:0] sec_off;
  logic              sec_hit;
  logic [DATA_W-1:0] rd_mux;

  assign sec_off = addr_i - ADDR_SECRET;
  assign sec_hit = (addr_i >= ADDR_SECRET) && (sec_off < ADDR_W'(SECRET_WORDS));

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_NAME0:    rd_mux = NAME0_VAL;
      ADDR_NAME1:    rd_mux = NAME1_VAL;
      ADDR_VERSION:  rd_mux = VERSION_VAL;
      ADDR_MODE:     rd_mux = DATA_W'(app_mode_i);
      ADDR_LED:      rd_mux = DATA_W'(led_i);
      ADDR_GPIO:     rd_mux = DATA_W'(gpio_i);
      ADDR_APP_BASE: rd_mux = app_start_i;
      ADDR_APP_LEN:  rd_mux = app_size_i;
      ADDR_HASH_PTR: rd_mux = hash_ptr_i;
      default: if (sec_hit) rd_mux = secret_i[sec_off[IDX_W-1:0]];
    endcase
  end

  // zero outside read cycles keeps the shared bus OR-able
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
    else           rdata_o <= '0;
  end
endmodule

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs import sys_cfg_pkg::*; #(
  parameter int                DATA_W       = 32,
  parameter int                SECRET_WORDS = 8,
  parameter logic [DATA_W-1:0] NAME0_VAL    = 32'h6366_6731,
  parameter logic [DATA_W-1:0] NAME1_VAL    = 32'h7265_6773,
  parameter logic [DATA_W-1:0] VERSION_VAL  = 32'h0000_0003
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [LED_W-1:0]    led_o,
  input  logic [GPIO_W-1:0]   gpio_i,
  output logic [GPIO_W-1:0]   gpio_o,
  output logic                app_mode_o
);
  logic wr_stb, rd_stb, mode_set;
  logic [DATA_W-1:0] app_start, app_size, hash_ptr;
  logic [SECRET_WORDS-1:0][DATA_W-1:0] secret;

  assign wr_stb   = cs_i & we_i;
  assign rd_stb   = cs_i & ~we_i;
  assign mode_set = wr_stb && (addr_i == ADDR_MODE) && (|wdata_i);

  cfg_mode_lock u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (mode_set),
    .app_mode_o (app_mode_o)
  );

  cfg_reg_file #(.DATA_W(DATA_W), .SECRET_WORDS(SECRET_WORDS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_stb),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .lock_i      (app_mode_o),
    .led_o       (led_o),
    .gpio_o      (gpio_o),
    .app_start_o (app_start),
    .app_size_o  (app_size),
    .hash_ptr_o  (hash_ptr),
    .secret_o    (secret)
  );

  cfg_read_mux #(
    .DATA_W(DATA_W), .SECRET_WORDS(SECRET_WORDS),
    .NAME0_VAL(NAME0_VAL), .NAME1_VAL(NAME1_VAL), .VERSION_VAL(VERSION_VAL)
  ) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_stb),
    .addr_i      (addr_i),
    .app_mode_i  (app_mode_o),
    .led_i       (led_o),
    .gpio_i      (gpio_i),
    .app_start_i (app_start),
    .app_size_i  (app_size),
    .hash_ptr_i  (hash_ptr),
    .secret_i    (secret),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/sys_cfg_regs_chk.sv
module sys_cfg_regs_chk import sys_cfg_pkg::*; #(
  parameter int DATA_W       = 32,
  parameter int SECRET_WORDS = 8
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                cs_i,
  input logic                                we_i,
  input logic [ADDR_W-1:0]                   addr_i,
  input logic [DATA_W-1:0]                   wdata_i,
  input logic [DATA_W-1:0]                   rdata_o,
  input logic [LED_W-1:0]                    led_o,
  input logic                                app_mode_o,
  input logic [DATA_W-1:0]                   app_start,
  input logic [DATA_W-1:0]                   app_size,
  input logic [DATA_W-1:0]                   hash_ptr,
  input logic [SECRET_WORDS-1:0][DATA_W-1:0] secret
);
  logic rd_req, mapped;
  assign rd_req = cs_i && !we_i;
  assign mapped = (addr_i <= ADDR_VERSION) || (addr_i == ADDR_MODE) ||
                  (addr_i == ADDR_LED) || (addr_i == ADDR_GPIO) ||
                  (addr_i == ADDR_APP_BASE) || (addr_i == ADDR_APP_LEN) ||
                  (addr_i == ADDR_HASH_PTR) ||
                  ((addr_i >= ADDR_SECRET) &&
                   ({1'b0, addr_i} < ({1'b0, ADDR_SECRET} + (ADDR_W+1)'(SECRET_WORDS))));

  a_r2_mode_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_mode_o |=> app_mode_o);

  a_r3_led_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i == ADDR_LED) |=> led_o == $past(wdata_i[LED_W-1:0]));

  a_r5_priv_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_mode_o |=> ($stable(app_start) && $stable(app_size) && $stable(hash_ptr)));

  a_r6_secret_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_mode_o |=> $stable(secret));

  a_r7_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !mapped) |=> rdata_o == '0);

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> rdata_o == '0);
endmodule

bind sys_cfg_regs sys_cfg_regs_chk #(.DATA_W(DATA_W), .SECRET_WORDS(SECRET_WORDS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .led_o      (led_o),
  .app_mode_o (app_mode_o),
  .app_start  (app_start),
  .app_size   (app_size),
  .hash_ptr   (hash_ptr),
  .secret     (secret)
);

// File: tb/sys_cfg_regs_bench.sv
`timescale 1ns/1ps
module sys_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  led;
  logic [3:0]  gpio_in = '0;
  logic [3:0]  gpio_out;
  logic        app_mode;

  int n_cmp = 0, n_err = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic [31:0] sec_m[8];

  always #2 clk = ~clk;

  sys_cfg_regs u_sys_cfg_regs (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .led_o(led), .gpio_i(gpio_in),
    .gpio_o(gpio_out), .app_mode_o(app_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: read data appears the cycle after the request
  always @(posedge clk) rd_seen <= cs && !we && rst_ni;
  always @(negedge clk) begin
    #1;
    if (rd_seen && exp_q.size() != 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9 led reset", 32'(led), 0);
    check("R9 gpio reset", 32'(gpio_out), 0);
    check("R2 mode reset", 32'(app_mode), 0);
    check("R8 idle rdata", rdata, 0);

    rd(8'h00, 32'h6366_6731, "R1 name0");
    rd(8'h01, 32'h7265_6773, "R1 name1");
    rd(8'h02, 32'h0000_0003, "R1 version");
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h02, 32'h1234_5678);
    rd(8'h00, 32'h6366_6731, "R1 name0 after write");
    rd(8'h02, 32'h0000_0003, "R1 version after write");
    rd(8'h0c, 0, "R9 app start reset");
    rd(8'h10, 0, "R9 hash reset");
    rd(8'h27, 0, "R9 secret reset");
    rd(8'h08, 0, "R2 mode reads 0");

    wr(8'h09, 32'hFFFF_FFF5);
    check("R3 led drive", 32'(led), 32'h5);
    rd(8'h09, 32'h5, "R3 led readback");
    wr(8'h0a, 32'h0000_003A);
    check("R4 gpio drive", 32'(gpio_out), 32'hA);
    gpio_in = 4'h6;
    rd(8'h0a, 32'h6, "R4 gpio pin read");

    wr(8'h0c, 32'h4000_0000);
    wr(8'h0d, 32'h0000_1F00);
    wr(8'h10, 32'h0000_3A5C);
    rd(8'h0c, 32'h4000_0000, "R5 app start");
    rd(8'h0d, 32'h0000_1F00, "R5 app size");
    rd(8'h10, 32'h0000_3A5C, "R5 hash pointer");
    for (int i = 0; i < 8; i++) begin
      sec_m[i] = 32'hC0DE_0000 ^ (32'(i) * 32'h0101_1111);
      wr(8'h20 + 8'(i), sec_m[i]);
    end
    for (int i = 0; i < 8; i++) rd(8'h20 + 8'(i), sec_m[i], "R6 secret fw mode");

    rd(8'h03, 0, "R7 unmapped 0x03");
    rd(8'h0b, 0, "R7 unmapped 0x0b");
    rd(8'h28, 0, "R7 unmapped 0x28");
    rd(8'hFF, 0, "R7 unmapped 0xff");
    drain();
    check("R8 idle after reads", rdata, 0);

    wr(8'h08, 0);
    check("R2 zero write keeps fw mode", 32'(app_mode), 0);
    wr(8'h08, 32'h0000_0100);
    check("R2 nonzero sets mode", 32'(app_mode), 1);
    rd(8'h08, 1, "R2 mode readback");

    wr(8'h0c, 32'hDEAD_0001);
    wr(8'h0d, 32'hDEAD_0002);
    wr(8'h10, 32'hDEAD_0003);
    for (int i = 0; i < 8; i++) wr(8'h20 + 8'(i), 32'hBAD0_0000 + 32'(i));
    rd(8'h0c, 32'h4000_0000, "R5 app start locked");
    rd(8'h0d, 32'h0000_1F00, "R5 app size locked");
    rd(8'h10, 32'h0000_3A5C, "R5 hash pointer locked");
    for (int i = 0; i < 8; i++) rd(8'h20 + 8'(i), sec_m[i], "R6 secret locked");
    wr(8'h09, 32'h2);
    check("R3 led writable in app mode", 32'(led), 32'h2);
    wr(8'h0a, 32'h5);
    check("R4 gpio writable in app mode", 32'(gpio_out), 32'h5);
    wr(8'h08, 0);
    check("R2 mode sticky", 32'(app_mode), 1);
    drain();

    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    check("R2 reset clears mode", 32'(app_mode), 0);
    check("R9 led cleared", 32'(led), 0);
    check("R9 gpio cleared", 32'(gpio_out), 0);
    rd(8'h0c, 0, "R9 app start cleared");
    rd(8'h23, 0, "R9 secret cleared");
    wr(8'h0d, 32'h0000_0077);
    rd(8'h0d, 32'h0000_0077, "R5 writable after reset");
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule